// File: doc/BRIEF.md
# Three-Dimensional DMA Address Sequencer

This block turns a stored transfer description into a stream of source and destination addresses. A transfer is a block made of frames, each frame made of arrays, each array a run of bytes. Every array the block produces appears on a valid/ready output as a source address, a destination address and a byte count. The memory data path that moves the bytes is outside the block. Sync events pace the block. Per set, an event releases either a single array or a whole frame.

Descriptions are written through a word-wide load port into a small table of parameter sets. Set 0 is the working set. Writing its last word arms the block. When the working set runs out, the block pulses a completion output carrying a code taken from the set. If the set names another table entry as its successor, that entry is copied into set 0 and the transfer carries on without outside help. A pause input holds off new work without disturbing the current position. A sync event that finds nothing to do raises a sticky error flag.

Top module: `dma3d_seq`

## Requirements
- R1: A set has eight 32-bit words, indexed 0 to 7. Word 0 holds the options: bit 0 selects the mode (0 = one array per event, 1 = one frame per event) and bits [13:8] hold the completion code. Word 1 holds the source base and word 3 the destination base. Word 2 holds the byte count in [15:0] and the arrays-per-frame count in [31:16]. Word 4 holds the array strides (source in [15:0], destination in [31:16]) and word 6 holds the frame strides in the same halves. Word 5 holds the successor index in [15:0] and the arrays-per-frame reload in [31:16]. Word 7 holds the frame count in [15:0]. Writing word 7 of set 0 arms the block: the first array then starts at the two base addresses, with `xfer_bytes` equal to the byte count.
- R2: In per-array mode each accepted sync event produces exactly one array. Within a frame, each address advances by its array stride, a 16-bit two's-complement value sign-extended to 32 bits.
- R3: In per-array mode, the first array of the next frame sits at the address of the frame's last array plus the frame stride. Every frame after the first holds the number of arrays given by the reload field.
- R4: In per-frame mode one accepted event produces all arrays of the current frame back to back, each completed by a handshake. The next frame starts at the previous frame's first address plus the frame stride, and every frame holds the count from word 2 (the reload field is not used).
- R5: With all four strides zero, every array of the block shows the same source and destination addresses.
- R6: In the cycle after the last array of the last frame is accepted, `done_pulse` is high for exactly one cycle, with `done_code` equal to bits [13:8] of that set's option word.
- R7: If the finishing set's successor index is nonzero and below the table size, that table entry replaces set 0. The next sync event is then served from the new set's base addresses with no further writes.
- R8: Sync events that arrive while `pause` is high are dropped without error. After `pause` falls, the next event continues from the position reached before the pause.
- R9: `miss_err` goes high and stays high until reset in either of two cases. The first is a sync event (with pause low) that finds no frames left and no reload under way. The second is an event that arrives while the block is busy and another event is already waiting.
- R10: After reset `xfer_valid`, `done_pulse` and `miss_err` are low, and the block holds no work, so a first sync event sets `miss_err`.
- R11: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid`, `xfer_src` and `xfer_dst` hold their values.
- R12: A sync event in the same cycle as the final handshake of a set that has a successor is kept. It is served from the successor set once the reload is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Parameter word write strobe |
| ld_set | input | SET_W | Table entry being written |
| ld_word | input | 3 | Word index within the entry |
| ld_data | input | 32 | Word value |
| sync_evt | input | 1 | Synchronization event, one cycle per event |
| pause | input | 1 | Masks sync events and holds off waiting work |
| xfer_valid | output | 1 | An array descriptor is offered |
| xfer_ready | input | 1 | Consumer accepts the offered array |
| xfer_src | output | 32 | Source address of the array |
| xfer_dst | output | 32 | Destination address of the array |
| xfer_bytes | output | 16 | Bytes in the array |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_code | output | 6 | Completion code of the finished set |
| miss_err | output | 1 | Sticky missed-event flag |

## Verification
The sharpest overlap is a new sync event landing on the same clock edge as the handshake that finishes a set with a successor. In that one edge the completion pulse, the copy of the successor into set 0 and the capture of the event must all happen. The bench raises `sync_evt` in the cycle it raises `xfer_ready` on the last array. It then passes only if three things hold: the completion code is the old set's, the next array appears at the successor's base addresses without another event, and `miss_err` stays low. A second overlap is an event arriving while a frame is still being handed out. The bench holds `xfer_ready` low, queues one event and then sends a third, expecting the error flag only for the third.

// File: rtl/dma3d_pkg.sv
// Package: shared layout of a parameter set and field decoders.
// Assumes a set is eight 32-bit words; the word index of each field is
// fixed because the loader arms on the last word and links copy whole sets.
package dma3d_pkg;

    localparam int SET_WORDS = 8;
    localparam int WORD_W    = 32;
    localparam int CNT_W     = 16;
    localparam int STR_W     = 16;
    localparam int CODE_W    = 6;

    localparam int IX_OPT  = 0;
    localparam int IX_SRC  = 1;
    localparam int IX_CNT  = 2;
    localparam int IX_DST  = 3;
    localparam int IX_ASTR = 4;
    localparam int IX_LINK = 5;
    localparam int IX_FSTR = 6;
    localparam int IX_FRM  = 7;

    typedef logic [SET_WORDS-1:0][WORD_W-1:0] pset_t;

    // Per-frame mode bit
    function automatic logic f_frame_mode(input pset_t p);
        return p[IX_OPT][0];
    endfunction

    function automatic logic [CODE_W-1:0] f_code(input pset_t p);
        return p[IX_OPT][8 +: CODE_W];
    endfunction

    function automatic logic [CNT_W-1:0] f_bytes(input pset_t p);
        return p[IX_CNT][0 +: CNT_W];
    endfunction

    function automatic logic [CNT_W-1:0] f_arrays(input pset_t p);
        return p[IX_CNT][CNT_W +: CNT_W];
    endfunction

    function automatic logic [CNT_W-1:0] f_reload(input pset_t p);
        return p[IX_LINK][CNT_W +: CNT_W];
    endfunction

    function automatic logic [CNT_W-1:0] f_link(input pset_t p);
        return p[IX_LINK][0 +: CNT_W];
    endfunction

    function automatic logic [CNT_W-1:0] f_frames(input pset_t p);
        return p[IX_FRM][0 +: CNT_W];
    endfunction

    // Stride of one lane (0 = source, 1 = destination) from a stride word
    function automatic logic [STR_W-1:0] f_lane_str(input logic [WORD_W-1:0] w,
                                                    input int lane);
        return (lane == 0) ? w[0 +: STR_W] : w[STR_W +: STR_W];
    endfunction

endpackage

// File: rtl/dma3d_param_store.sv
// Parameter table: NSETS entries of one parameter set each. Entry 0 is the
// working set seen by the sequencer. A link copy of an entry into entry 0
// takes priority over a load-port write to entry 0 in the same cycle.
// Assumes copy_idx is a valid, nonzero index when copy_en is high.
module dma3d_param_store
    import dma3d_pkg::*;
#(
    parameter int NSETS = 4,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [2:0]        wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              copy_en,
    input  logic [SET_W-1:0]  copy_idx,
    output pset_t             act_set
);

    pset_t mem [NSETS];

    // Table storage: clear on reset, word writes, whole-set link copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSETS; s++) mem[s] <= '0;
        end else begin
            if (wr_en) mem[wr_set][wr_word] <= wr_data;
            if (copy_en) mem[0] <= mem[copy_idx];
        end
    end

    // Working set view
    always_comb act_set = mem[0];

endmodule

// File: rtl/dma3d_addr_lane.sv
// One address lane (source or destination). Holds the current array
// address and the address of the first array of the current frame.
// On each accepted array it steps by the array stride, or at a frame end by
// the frame stride: from the frame start in per-frame mode, from the last
// array address in per-array mode. Strides are sign-extended.
module dma3d_addr_lane
    import dma3d_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] base,
    input  logic              step,
    input  logic              last_arr,
    input  logic              frame_mode,
    input  logic [STR_W-1:0]  astr,
    input  logic [STR_W-1:0]  fstr,
    output logic [WORD_W-1:0] cur
);

    localparam int EXT_W = WORD_W - STR_W;

    logic [WORD_W-1:0] frm_start;
    logic [WORD_W-1:0] astr_x;
    logic [WORD_W-1:0] fstr_x;
    logic [WORD_W-1:0] next_frame;

    // Sign extension of both strides and next-frame address
    always_comb begin
        astr_x     = {{EXT_W{astr[STR_W-1]}}, astr};
        fstr_x     = {{EXT_W{fstr[STR_W-1]}}, fstr};
        next_frame = frame_mode ? (frm_start + fstr_x) : (cur + fstr_x);
    end

    // Address registers: load from base, step per accepted array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur       <= '0;
            frm_start <= '0;
        end else if (load) begin
            cur       <= base;
            frm_start <= base;
        end else if (step) begin
            if (last_arr) begin
                cur       <= next_frame;
                frm_start <= next_frame;
            end else begin
                cur <= cur + astr_x;
            end
        end
    end

    // R5: zero strides leave the lane address unchanged across a step
    p_fixed_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && astr == '0 && fstr == '0) |=> $stable(cur));

endmodule

// File: rtl/dma3d_ctrl.sv
// Sequencer control: array and frame counters, event acceptance with a
// one-deep waiting slot, pause masking, completion and link reload.
// Assumes set 0 is rewritten only while no array is being offered.
module dma3d_ctrl
    import dma3d_pkg::*;
#(
    parameter int NSETS = 4,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              sync_evt,
    input  logic              pause,
    input  logic              xfer_ready,
    input  pset_t             act_set,
    output logic              busy,
    output logic              step,
    output logic              last_arr,
    output logic              load,
    output logic              frame_mode,
    output logic              copy_en,
    output logic [SET_W-1:0]  copy_idx,
    output logic              done_pulse,
    output logic [CODE_W-1:0] done_code,
    output logic              miss_err
);

    logic [CNT_W-1:0] arr_left;
    logic [CNT_W-1:0] frm_left;
    logic             waiting;
    logic             last_blk;
    logic             link_ok;
    logic [CNT_W-1:0] link_fld;
    logic             evt;
    logic             can_run;
    logic             busy_n, wait_n, miss_n;

    // Field decode and handshake qualifiers
    always_comb begin
        frame_mode = f_frame_mode(act_set);
        link_fld   = f_link(act_set);
        link_ok    = (link_fld != '0) && (32'(link_fld) < NSETS);
        copy_idx   = link_fld[SET_W-1:0];
        step       = busy && xfer_ready;
        last_arr   = (arr_left == 1);
        last_blk   = last_arr && (frm_left == 1);
        copy_en    = step && last_blk && link_ok;
        evt        = sync_evt && !pause;
        can_run    = !load && !busy && !pause && (frm_left != '0);
    end

    // Reload request: one cycle after arming or after a link copy
    always_ff @(posedge clk) begin
        if (!rst_n) load <= 1'b0;
        else        load <= arm || copy_en;
    end

    // Array and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_left <= '0;
            frm_left <= '0;
        end else if (load) begin
            arr_left <= f_arrays(act_set);
            frm_left <= f_frames(act_set);
        end else if (step) begin
            if (last_arr) begin
                arr_left <= frame_mode ? f_arrays(act_set) : f_reload(act_set);
                frm_left <= frm_left - 1'b1;
            end else begin
                arr_left <= arr_left - 1'b1;
            end
        end
    end

    // Next state of busy flag, waiting slot and error flag
    always_comb begin
        busy_n = busy;
        wait_n = waiting;
        miss_n = miss_err;
        if (load) busy_n = 1'b0;
        else if (step && (last_arr || !frame_mode)) busy_n = 1'b0;
        if (waiting) begin
            if (can_run) begin
                busy_n = 1'b1;
                wait_n = 1'b0;
            end else if (!busy && !load && frm_left == '0) begin
                miss_n = 1'b1;
                wait_n = 1'b0;
            end
        end
        if (evt) begin
            if (!load && !busy && frm_left == '0) miss_n = 1'b1;
            else if (!waiting && can_run)         busy_n = 1'b1;
            else if (!wait_n)                     wait_n = 1'b1;
            else                                  miss_n = 1'b1;
        end
    end

    // State registers for busy, waiting slot and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            waiting  <= 1'b0;
            miss_err <= 1'b0;
        end else begin
            busy     <= busy_n;
            waiting  <= wait_n;
            miss_err <= miss_n;
        end
    end

    // Completion strobe and code of the finishing set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse <= 1'b0;
            done_code  <= '0;
        end else begin
            done_pulse <= step && last_blk;
            if (step && last_blk) done_code <= f_code(act_set);
        end
    end

    // R6: completion strobe lasts one cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R9: missed-event flag is sticky
    p_miss_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |=> miss_err);

    // R8: no array starts while pause is high
    p_pause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pause) |=> !busy);

    // R4: an offered array always has a nonzero array count behind it
    p_arrays_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (arr_left != '0 && frm_left != '0));

endmodule

// File: rtl/dma3d_seq.sv
// Top of the three-dimensional address sequencer. Connects the parameter
// table, the control block and one address lane per direction (generated).
// Assumes the consumer holds xfer_ready only as long as it wants arrays.
module dma3d_seq
    import dma3d_pkg::*;
#(
    parameter int NSETS = 4,
    localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [SET_W-1:0]  ld_set,
    input  logic [2:0]        ld_word,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              sync_evt,
    input  logic              pause,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [CNT_W-1:0]  xfer_bytes,
    output logic              done_pulse,
    output logic [CODE_W-1:0] done_code,
    output logic              miss_err
);

    localparam int LANES = 2;

    pset_t             act_set;
    logic              arm;
    logic              copy_en;
    logic [SET_W-1:0]  copy_idx;
    logic              busy, step, last_arr, load, frame_mode;
    logic [WORD_W-1:0] lane_cur  [LANES];
    logic [WORD_W-1:0] lane_base [LANES];

    // Arming strobe: write of the last word of the working set
    always_comb arm = ld_en && (ld_set == '0) && (ld_word == 3'(IX_FRM));

    dma3d_param_store #(.NSETS(NSETS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ld_en),
        .wr_set   (ld_set),
        .wr_word  (ld_word),
        .wr_data  (ld_data),
        .copy_en  (copy_en),
        .copy_idx (copy_idx),
        .act_set  (act_set)
    );

    dma3d_ctrl #(.NSETS(NSETS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .sync_evt   (sync_evt),
        .pause      (pause),
        .xfer_ready (xfer_ready),
        .act_set    (act_set),
        .busy       (busy),
        .step       (step),
        .last_arr   (last_arr),
        .load       (load),
        .frame_mode (frame_mode),
        .copy_en    (copy_en),
        .copy_idx   (copy_idx),
        .done_pulse (done_pulse),
        .done_code  (done_code),
        .miss_err   (miss_err)
    );

    // Base address of each lane from the working set
    always_comb begin
        lane_base[0] = act_set[IX_SRC];
        lane_base[1] = act_set[IX_DST];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dma3d_addr_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .base       (lane_base[g]),
            .step       (step),
            .last_arr   (last_arr),
            .frame_mode (frame_mode),
            .astr       (f_lane_str(act_set[IX_ASTR], g)),
            .fstr       (f_lane_str(act_set[IX_FSTR], g)),
            .cur        (lane_cur[g])
        );
    end

    // Output view of the offered array
    always_comb begin
        xfer_valid = busy;
        xfer_src   = lane_cur[0];
        xfer_dst   = lane_cur[1];
        xfer_bytes = f_bytes(act_set);
    end

    // R11: an offered array holds until it is accepted
    p_offer_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_ready) |=>
            (xfer_valid && $stable(xfer_src) && $stable(xfer_dst)));

endmodule

// File: tb/dma3d_seq_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dma3d_seq_bench;

    localparam int NSETS = 4;
    localparam int SET_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [SET_W-1:0] ld_set = '0;
    logic [2:0]  ld_word = '0;
    logic [31:0] ld_data = '0;
    logic        sync_evt = 1'b0;
    logic        pause = 1'b0;
    logic        xfer_ready = 1'b0;
    logic        xfer_valid;
    logic [31:0] xfer_src, xfer_dst;
    logic [15:0] xfer_bytes;
    logic        done_pulse;
    logic [5:0]  done_code;
    logic        miss_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma3d_seq #(.NSETS(NSETS)) u_dma3d_seq (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_set(ld_set),
        .ld_word(ld_word), .ld_data(ld_data), .sync_evt(sync_evt),
        .pause(pause), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_bytes(xfer_bytes),
        .done_pulse(done_pulse), .done_code(done_code), .miss_err(miss_err)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sync_evt = 1'b0; pause = 1'b0; xfer_ready = 1'b0; ld_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int s, input int w, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_set = SET_W'(s); ld_word = 3'(w); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Writes a whole set; word 7 last so set 0 is armed at the end
    task automatic wr_set(input int s, input logic [31:0] w0, w1, w2, w3,
                          w4, w5, w6, w7);
        wr(s, 0, w0); wr(s, 1, w1); wr(s, 2, w2); wr(s, 3, w3);
        wr(s, 4, w4); wr(s, 5, w5); wr(s, 6, w6); wr(s, 7, w7);
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
    endtask

    // Waits for an offer, checks it, accepts it, checks the completion strobe
    task automatic take(input logic [31:0] es, ed, input logic [15:0] eb,
                        input bit edone, input logic [5:0] ecode,
                        input bit evt_same, input string tag);
        for (int i = 0; i < 20 && !xfer_valid; i++) @(negedge clk);
        chk(xfer_valid === 1'b1, {tag, " valid"}, 32'(xfer_valid), 32'd1);
        chk(xfer_src === es, {tag, " src"}, xfer_src, es);
        chk(xfer_dst === ed, {tag, " dst"}, xfer_dst, ed);
        chk(xfer_bytes === eb, {tag, " bytes"}, 32'(xfer_bytes), 32'(eb));
        xfer_ready = 1'b1;
        sync_evt = evt_same;
        @(negedge clk);
        xfer_ready = 1'b0;
        sync_evt = 1'b0;
        chk(done_pulse === edone, {tag, " done"}, 32'(done_pulse), 32'(edone));
        if (edone) begin
            chk(done_code === ecode, {tag, " code"}, 32'(done_code), 32'(ecode));
            @(negedge clk);
            chk(done_pulse === 1'b0, {tag, " done one cycle"}, 32'(done_pulse), 32'd0);
        end
    endtask

    task automatic expect_idle(input string tag);
        repeat (4) @(negedge clk);
        chk(xfer_valid === 1'b0, tag, 32'(xfer_valid), 32'd0);
    endtask

    // R10: reset state and first event with no work
    task automatic t_reset();
        do_reset();
        chk(xfer_valid === 1'b0, "R10 valid after reset", 32'(xfer_valid), 0);
        chk(done_pulse === 1'b0, "R10 done after reset", 32'(done_pulse), 0);
        chk(miss_err === 1'b0, "R10 miss after reset", 32'(miss_err), 0);
        pulse_sync();
        @(negedge clk);
        chk(miss_err === 1'b1, "R10 R9 event with no work", 32'(miss_err), 1);
    endtask

    // R1 R2 R3 R6 R9: per-array mode, signed strides, reload count
    task automatic t_array_mode();
        do_reset();
        wr_set(0, 32'h0000_0500, 32'h0000_1000, 32'h0003_0004, 32'h0000_2000,
               32'h0020_0010, 32'h0002_0000, 32'hFFC0_0100, 32'h0000_0002);
        pulse_sync(); take(32'h1000, 32'h2000, 16'd4, 0, 0, 0, "R1 first array");
        expect_idle("R2 one array per event");
        pulse_sync(); take(32'h1010, 32'h2020, 16'd4, 0, 0, 0, "R2 array stride");
        pulse_sync(); take(32'h1020, 32'h2040, 16'd4, 0, 0, 0, "R2 third array");
        pulse_sync(); take(32'h1120, 32'h2000, 16'd4, 0, 0, 0, "R3 frame stride from last array");
        pulse_sync(); take(32'h1130, 32'h2020, 16'd4, 1, 6'd5, 0, "R3 R6 reload count and completion");
        chk(miss_err === 1'b0, "R9 no miss while work left", 32'(miss_err), 0);
        pulse_sync();
        @(negedge clk);
        chk(miss_err === 1'b1, "R9 event after block end", 32'(miss_err), 1);
        expect_idle("R9 no offer after block end");
    endtask

    // R4: per-frame mode, frame stride from the frame start
    task automatic t_frame_mode();
        do_reset();
        wr_set(0, 32'h0000_0901, 32'h0000_4000, 32'h0002_0008, 32'h0000_8000,
               32'hFFF8_0004, 32'h0005_0000, 32'h0000_0040, 32'h0000_0002);
        pulse_sync();
        take(32'h4000, 32'h8000, 16'd8, 0, 0, 0, "R4 frame0 array0");
        take(32'h4004, 32'h7FF8, 16'd8, 0, 0, 0, "R4 frame0 array1 same event");
        expect_idle("R4 frame ends the event");
        pulse_sync();
        take(32'h4040, 32'h8000, 16'd8, 0, 0, 0, "R4 frame1 from frame start");
        take(32'h4044, 32'h7FF8, 16'd8, 1, 6'd9, 0, "R4 R6 frame count ignores reload");
    endtask

    // R5: zero strides give a fixed address
    task automatic t_fixed();
        do_reset();
        wr_set(0, 32'h0000_0101, 32'hA000_0010, 32'h0002_0004, 32'hB000_0020,
               32'h0, 32'h0, 32'h0, 32'h0000_0002);
        pulse_sync();
        take(32'hA000_0010, 32'hB000_0020, 16'd4, 0, 0, 0, "R5 fixed a0");
        take(32'hA000_0010, 32'hB000_0020, 16'd4, 0, 0, 0, "R5 fixed a1");
        pulse_sync();
        take(32'hA000_0010, 32'hB000_0020, 16'd4, 0, 0, 0, "R5 fixed a2");
        take(32'hA000_0010, 32'hB000_0020, 16'd4, 1, 6'd1, 0, "R5 fixed a3");
    endtask

    // R7 R12: link reload with an event on the final handshake
    task automatic t_link();
        do_reset();
        wr_set(1, 32'h0000_0700, 32'h0000_0300, 32'h0001_0002, 32'h0000_0600,
               32'h0, 32'h0001_0000, 32'h0010_0008, 32'h0000_0002);
        wr_set(0, 32'h0000_0301, 32'h0000_0050, 32'h0002_0004, 32'h0000_0090,
               32'h0004_0004, 32'h0000_0001, 32'h0, 32'h0000_0001);
        pulse_sync();
        take(32'h50, 32'h90, 16'd4, 0, 0, 0, "R7 set0 a0");
        take(32'h54, 32'h94, 16'd4, 1, 6'd3, 1, "R12 final handshake with event");
        take(32'h300, 32'h600, 16'd2, 0, 0, 0, "R12 R7 kept event served from linked set");
        chk(miss_err === 1'b0, "R12 no miss on overlap", 32'(miss_err), 0);
        pulse_sync();
        take(32'h308, 32'h610, 16'd2, 1, 6'd7, 0, "R7 linked set completes");
    endtask

    // R8: pause drops events and keeps position
    task automatic t_pause();
        do_reset();
        wr_set(0, 32'h0000_0200, 32'h0000_0100, 32'h0002_0002, 32'h0000_0200,
               32'h0004_0002, 32'h0000_0000, 32'h0, 32'h0000_0001);
        pulse_sync(); take(32'h100, 32'h200, 16'd2, 0, 0, 0, "R8 before pause");
        pause = 1'b1;
        pulse_sync();
        expect_idle("R8 no offer while paused");
        chk(miss_err === 1'b0, "R8 no error while paused", 32'(miss_err), 0);
        pause = 1'b0;
        expect_idle("R8 paused event dropped");
        pulse_sync(); take(32'h102, 32'h204, 16'd2, 1, 6'd2, 0, "R8 resume keeps position");
    endtask

    // R9 R11: overrun while busy, offer held without ready
    task automatic t_overrun();
        do_reset();
        wr_set(0, 32'h0000_0001, 32'h0000_7000, 32'h0003_0001, 32'h0000_7800,
               32'h0001_0001, 32'h0, 32'h0, 32'h0000_0002);
        pulse_sync();
        repeat (3) @(negedge clk);
        chk(xfer_valid === 1'b1 && xfer_src === 32'h7000, "R11 offer held",
            xfer_src, 32'h7000);
        pulse_sync();
        @(negedge clk);
        chk(miss_err === 1'b0, "R9 one waiting event allowed", 32'(miss_err), 0);
        pulse_sync();
        @(negedge clk);
        chk(miss_err === 1'b1, "R9 second waiting event missed", 32'(miss_err), 1);
        chk(xfer_src === 32'h7000, "R11 src stable without ready", xfer_src, 32'h7000);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_array_mode();
        t_frame_mode();
        t_fixed();
        t_link();
        t_pause();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule